// File: doc/BRIEF.md
# Cluster Wake Sequencer

This block brings a four-core cluster out of deep sleep. On a wake request it first powers and initialises the shared cache domain. It then brings up each selected core domain in turn. Every step of a bring-up is a handshake. The block raises a one-cycle request carrying a step identifier, waits for the matching completion input, and only then moves on. Power switches, clock generators and array contents live outside the block and are seen only through these handshakes. Each wait is bounded by a programmable timeout, and a timeout leaves a sticky error code that names the step that stalled.

Two flavours of sequence exist. In boot mode the core steps follow the cache directly. In runtime mode, for each core, the block first wins a shared register-bus multiplexer. After the core steps it blocks interrupts and loads the base-address register as an extra step. It then pulses a reset to every thread and waits until each thread reports that it has parked in the special level-15 stop state. Only then does it release the interrupt block and the bus.

A separate power-down path enforces the hierarchy: a deeper sleep level that switches off the cache is refused unless every core beneath it ends up off. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready back-pressure.

Top module: `clwake_seq`

## Requirements
- R1: When the cache is off, an accepted wake first issues cache steps with step_id 0 through 9 in ascending order. Each step is a step_req high for exactly one cycle, and the next step is issued only after step_done has been seen. cache_pwr goes high once step 9 completes.
- R2: No core step (step_id 10 or above) is issued while cache_pwr is low. When cache_pwr is already high at acceptance, the cache steps are skipped entirely.
- R3: Each selected core that is not already powered receives core steps with step_id 10 through 16 in order, with step_core giving its index. Cores are handled one at a time in ascending index, and the core's core_pwr bit is set when its sequence ends.
- R4: In runtime mode, mux_req rises before a core's first step and stays high until that core's sequence ends. Core steps start only after mux_grant is seen. In boot mode mux_req never rises.
- R5: In runtime mode, after step 16 completes, irq_block goes high and step 17 (base-address load) is issued. After step 17 completes, thread_reset pulses for one cycle with exactly the low NTHREAD bits set.
- R6: After the thread reset, irq_block stays high and the core does not complete until every one of the low NTHREAD bits of thread_stop15 has been seen high at least once since the pulse. Bits at NTHREAD and above have no effect.
- R7: With a nonzero tmo_limit L, a completion is accepted in any of the L cycles after a step request, or after entry to a mux or rendezvous wait. If none arrives, err rises and err_code holds the step id, 18 for a mux wait or 19 for a rendezvous wait. err and err_code then stay unchanged until reset, busy is low and wake requests are ignored. A tmo_limit of 0 disables the timeout.
- R8: busy is high from the cycle after a wake is accepted until the sequence ends, and done is then a one-cycle pulse with busy low. A wake_req while busy has no effect.
- R9: A power-down request with pd_level below 5 is acknowledged with no change. Levels 5 to 10 switch off the cores in pd_cores. Levels 11 and above switch off those cores and also the cache.
- R10: A power-down request is refused with pd_nak, changing nothing, when the block is busy, or when it would switch off the cache while any core would remain on. cache_pwr never falls while any core_pwr bit is high.
- R11: After reset, cache_pwr, core_pwr, busy, done, err, step_req, mux_req, irq_block and thread_reset are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_req | input | 1 | Start a wake sequence (sampled when idle) |
| wake_cores | input | NCORE | Cores to bring up |
| runtime | input | 1 | 1: runtime sequence, 0: boot sequence |
| tmo_limit | input | TO_W | Per-wait timeout in cycles, 0 disables |
| step_req | output | 1 | One-cycle step request |
| step_id | output | 5 | Identifier of the requested step |
| step_core | output | CORE_W | Core index for core steps |
| step_done | input | 1 | Completion of the current step |
| mux_req | output | 1 | Request for the shared register-bus mux |
| mux_grant | input | 1 | Grant for the shared register-bus mux |
| irq_block | output | 1 | Block interrupts to the core being woken |
| thread_reset | output | THR_W | One-cycle reset pulse per thread |
| thread_stop15 | input | THR_W | Per-thread report of reaching stop level 15 |
| pd_req | input | 1 | Power-down request |
| pd_cores | input | NCORE | Cores named by the power-down request |
| pd_level | input | 4 | Target sleep level, larger is deeper |
| pd_ack | output | 1 | Power-down applied (one cycle) |
| pd_nak | output | 1 | Power-down refused (one cycle) |
| cache_pwr | output | 1 | Cache domain is up |
| core_pwr | output | NCORE | Per-core domain is up |
| busy | output | 1 | Wake sequence in progress |
| done | output | 1 | Wake sequence finished (one cycle) |
| err | output | 1 | Sticky timeout error |
| err_code | output | 5 | Step or wait that timed out |

## Verification
The bench builds the block with four cores, an eight-bit thread vector of which four threads take part, and an eight-bit timeout field. The spare upper thread bits let it show that reports from unused threads cannot complete a rendezvous. The narrow timeout field keeps the timeout edge reachable in a few cycles, so a step answered on exactly the last allowed cycle can be placed beside one answered a cycle late. Four cores let a single runtime wake walk the full per-core loop with bus arbitration and rendezvous repeated in ascending order.

// File: rtl/clwake_pkg.sv
package clwake_pkg;
  localparam int ID_W = 5;
  typedef logic [ID_W-1:0] step_id_t;

  // step identifiers; order is the bring-up order
  localparam step_id_t ID_CACHE_FIRST = 5'd0;
  localparam step_id_t ID_CACHE_LAST  = 5'd9;
  localparam step_id_t ID_CORE_FIRST  = 5'd10;
  localparam step_id_t ID_CORE_LAST   = 5'd16;
  localparam step_id_t ID_BASE_LOAD   = 5'd17;
  localparam step_id_t CODE_MUX_TMO   = 5'd18;
  localparam step_id_t CODE_RDV_TMO   = 5'd19;

  typedef enum logic [2:0] {
    S_IDLE, S_STEP, S_PICK, S_MUXW, S_TRST, S_RDV, S_ERR
  } seq_state_t;
endpackage

// File: rtl/clwake_timer.sv
module clwake_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            at_limit
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  // last allowed waiting cycle; a zero limit never expires
  assign at_limit = (limit != '0) && (cnt == limit - 1'b1);
endmodule

// File: rtl/clwake_rdv.sv
module clwake_rdv #(
  parameter int THR_W   = 8,
  parameter int NTHREAD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [THR_W-1:0] stop_in,
  output logic             all_done
);
  function automatic logic [THR_W-1:0] live_mask();
    logic [THR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NTHREAD; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [THR_W-1:0] LIVE = live_mask();

  logic [THR_W-1:0] seen_q;
  logic [THR_W-1:0] seen_now;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) seen_q <= '0;
    else               seen_q <= seen_q | stop_in;
  end

  assign seen_now = seen_q | stop_in;
  assign all_done = &(seen_now | ~LIVE);

  // collected reports never drop while the rendezvous is open
  assert_seen_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && $past(!arm)) |-> ((seen_q & $past(seen_q)) == $past(seen_q)))
    else $error("rendezvous bits lost");
endmodule

// File: rtl/clwake_pick.sv
module clwake_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/clwake_pwr_guard.sv
module clwake_pwr_guard #(
  parameter int NCORE         = 4,
  parameter int CORE_W        = 2,
  parameter int CORE_OFF_LVL  = 5,
  parameter int CACHE_OFF_LVL = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              set_cache,
  input  logic              set_core,
  input  logic [CORE_W-1:0] set_idx,
  input  logic              pd_req,
  input  logic [NCORE-1:0]  pd_cores,
  input  logic [3:0]        pd_level,
  output logic              cache_pwr,
  output logic [NCORE-1:0]  core_pwr,
  output logic              pd_ack,
  output logic              pd_nak
);
  logic             hit_cores, hit_cache, allowed;
  logic [NCORE-1:0] cores_after;

  assign hit_cores   = pd_level >= 4'(CORE_OFF_LVL);
  assign hit_cache   = pd_level >= 4'(CACHE_OFF_LVL);
  assign cores_after = core_pwr & ~(hit_cores ? pd_cores : '0);
  assign allowed     = !busy && (!hit_cache || cores_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_pwr <= 1'b0;
      core_pwr  <= '0;
      pd_ack    <= 1'b0;
      pd_nak    <= 1'b0;
    end else begin
      pd_ack <= 1'b0;
      pd_nak <= 1'b0;
      if (set_cache) cache_pwr <= 1'b1;
      if (set_core)  core_pwr[set_idx] <= 1'b1;
      if (pd_req) begin
        if (allowed) begin
          pd_ack   <= 1'b1;
          core_pwr <= cores_after;
          if (hit_cache) cache_pwr <= 1'b0;
        end else begin
          pd_nak <= 1'b1;
        end
      end
    end
  end

  assert_cache_last_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cache_pwr) |-> (core_pwr == '0))
    else $error("cache dropped with a core still on");
  assert_core_needs_cache_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_core |-> cache_pwr)
    else $error("core finished without cache");
endmodule

// File: rtl/clwake_seq.sv
module clwake_seq
  import clwake_pkg::*;
#(
  parameter int NCORE         = 4,
  parameter int THR_W         = 8,
  parameter int NTHREAD       = 4,
  parameter int TO_W          = 16,
  parameter int CORE_OFF_LVL  = 5,
  parameter int CACHE_OFF_LVL = 11,
  localparam int CORE_W       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_req,
  input  logic [NCORE-1:0]  wake_cores,
  input  logic              runtime,
  input  logic [TO_W-1:0]   tmo_limit,
  output logic              step_req,
  output logic [ID_W-1:0]   step_id,
  output logic [CORE_W-1:0] step_core,
  input  logic              step_done,
  output logic              mux_req,
  input  logic              mux_grant,
  output logic              irq_block,
  output logic [THR_W-1:0]  thread_reset,
  input  logic [THR_W-1:0]  thread_stop15,
  input  logic              pd_req,
  input  logic [NCORE-1:0]  pd_cores,
  input  logic [3:0]        pd_level,
  output logic              pd_ack,
  output logic              pd_nak,
  output logic              cache_pwr,
  output logic [NCORE-1:0]  core_pwr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ID_W-1:0]   err_code
);
  function automatic logic [THR_W-1:0] live_mask();
    logic [THR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NTHREAD; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [THR_W-1:0] LIVE = live_mask();

  seq_state_t        state;
  step_id_t          cur_id, code_q;
  logic              fresh, rt_q, irq_q, mux_q, done_q;
  logic [CORE_W-1:0] cur_core, pick_idx;
  logic [NCORE-1:0]  pend;
  logic              pick_any, at_limit, tmr_run, wait_evt, tmo;
  logic              rdv_all, set_cache, fin_core;

  assign tmr_run = (state == S_STEP && !fresh) || state == S_MUXW || state == S_RDV;

  always_comb begin
    case (state)
      S_STEP:  wait_evt = step_done;
      S_MUXW:  wait_evt = mux_grant;
      S_RDV:   wait_evt = rdv_all;
      default: wait_evt = 1'b0;
    endcase
  end

  assign tmo       = tmr_run && at_limit && !wait_evt;
  assign set_cache = state == S_STEP && !fresh && step_done && cur_id == ID_CACHE_LAST;
  assign fin_core  = (state == S_STEP && !fresh && step_done && cur_id == ID_CORE_LAST && !rt_q)
                   || (state == S_RDV && rdv_all);

  clwake_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmo_limit), .at_limit(at_limit)
  );

  clwake_rdv #(.THR_W(THR_W), .NTHREAD(NTHREAD)) u_rdv (
    .clk(clk), .rst_n(rst_n), .arm(state != S_RDV), .stop_in(thread_stop15),
    .all_done(rdv_all)
  );

  clwake_pick #(.N(NCORE), .W(CORE_W)) u_pick (
    .req(pend), .idx(pick_idx), .any(pick_any)
  );

  clwake_pwr_guard #(
    .NCORE(NCORE), .CORE_W(CORE_W),
    .CORE_OFF_LVL(CORE_OFF_LVL), .CACHE_OFF_LVL(CACHE_OFF_LVL)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .set_cache(set_cache), .set_core(fin_core), .set_idx(cur_core),
    .pd_req(pd_req), .pd_cores(pd_cores), .pd_level(pd_level),
    .cache_pwr(cache_pwr), .core_pwr(core_pwr), .pd_ack(pd_ack), .pd_nak(pd_nak)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_id   <= ID_CACHE_FIRST;
      code_q   <= '0;
      fresh    <= 1'b0;
      rt_q     <= 1'b0;
      irq_q    <= 1'b0;
      mux_q    <= 1'b0;
      done_q   <= 1'b0;
      cur_core <= '0;
      pend     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (wake_req) begin
          pend <= wake_cores & ~core_pwr;
          rt_q <= runtime;
          if (!cache_pwr) begin
            state  <= S_STEP;
            cur_id <= ID_CACHE_FIRST;
            fresh  <= 1'b1;
          end else begin
            state <= S_PICK;
          end
        end
        S_STEP: begin
          if (fresh) begin
            fresh <= 1'b0;
          end else if (step_done) begin
            if (cur_id == ID_CACHE_LAST) begin
              state <= S_PICK;
            end else if (cur_id == ID_CORE_LAST && rt_q) begin
              cur_id <= ID_BASE_LOAD;
              fresh  <= 1'b1;
              irq_q  <= 1'b1;
            end else if (cur_id == ID_CORE_LAST) begin
              pend[cur_core] <= 1'b0;
              state          <= S_PICK;
            end else if (cur_id == ID_BASE_LOAD) begin
              state <= S_TRST;
            end else begin
              cur_id <= cur_id + 1'b1;
              fresh  <= 1'b1;
            end
          end else if (tmo) begin
            state  <= S_ERR;
            code_q <= cur_id;
            mux_q  <= 1'b0;
          end
        end
        S_PICK: begin
          if (!pick_any) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cur_core <= pick_idx;
            if (rt_q) begin
              state <= S_MUXW;
              mux_q <= 1'b1;
            end else begin
              state  <= S_STEP;
              cur_id <= ID_CORE_FIRST;
              fresh  <= 1'b1;
            end
          end
        end
        S_MUXW: begin
          if (mux_grant) begin
            state  <= S_STEP;
            cur_id <= ID_CORE_FIRST;
            fresh  <= 1'b1;
          end else if (tmo) begin
            state  <= S_ERR;
            code_q <= CODE_MUX_TMO;
            mux_q  <= 1'b0;
          end
        end
        S_TRST: state <= S_RDV;
        S_RDV: begin
          if (rdv_all) begin
            irq_q          <= 1'b0;
            mux_q          <= 1'b0;
            pend[cur_core] <= 1'b0;
            state          <= S_PICK;
          end else if (tmo) begin
            state  <= S_ERR;
            code_q <= CODE_RDV_TMO;
            mux_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign step_req     = state == S_STEP && fresh;
  assign step_id      = cur_id;
  assign step_core    = cur_core;
  assign mux_req      = mux_q;
  assign irq_block    = irq_q;
  assign thread_reset = (state == S_TRST) ? LIVE : '0;
  assign busy         = state != S_IDLE && state != S_ERR;
  assign done         = done_q;
  assign err          = state == S_ERR;
  assign err_code     = code_q;

  assert_step_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req)
    else $error("step request longer than one cycle");
  assert_core_after_cache_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_id >= ID_CORE_FIRST) |-> cache_pwr)
    else $error("core step before cache is up");
  assert_mux_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_id >= ID_CORE_FIRST && rt_q) |-> mux_req)
    else $error("runtime core step without bus mux");
  assert_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_block) |-> $past(rdv_all))
    else $error("interrupts released before rendezvous");
  assert_tmo_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> err)
    else $error("timeout did not raise error");
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(err_code)))
    else $error("error not sticky");
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while busy");
endmodule

// File: tb/clwake_seq_test.sv
`timescale 1ns/1ps
module clwake_seq_test;
  localparam int NCORE = 4, THR_W = 8, NTHREAD = 4, TO_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake_req = 1'b0, runtime = 1'b0, step_done = 1'b0, mux_grant = 1'b0, pd_req = 1'b0;
  logic [NCORE-1:0] wake_cores = '0, pd_cores = '0, core_pwr;
  logic [TO_W-1:0] tmo_limit = 8'd8;
  logic [THR_W-1:0] thread_stop15 = '0, thread_reset;
  logic [3:0] pd_level = '0;
  logic step_req, mux_req, irq_block, pd_ack, pd_nak, cache_pwr, busy, done, err;
  logic [4:0] step_id, err_code;
  logic [1:0] step_core;

  clwake_seq #(.NCORE(NCORE), .THR_W(THR_W), .NTHREAD(NTHREAD), .TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_cores(wake_cores),
    .runtime(runtime), .tmo_limit(tmo_limit), .step_req(step_req), .step_id(step_id),
    .step_core(step_core), .step_done(step_done), .mux_req(mux_req), .mux_grant(mux_grant),
    .irq_block(irq_block), .thread_reset(thread_reset), .thread_stop15(thread_stop15),
    .pd_req(pd_req), .pd_cores(pd_cores), .pd_level(pd_level), .pd_ack(pd_ack),
    .pd_nak(pd_nak), .cache_pwr(cache_pwr), .core_pwr(core_pwr), .busy(busy),
    .done(done), .err(err), .err_code(err_code)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // responder state
  int resp_delay = 1, cd = 0, nlog = 0, trst_cnt = 0, tstage = 0;
  bit grant_en = 1, hi_only = 0, mux_seen = 0;
  int log_id[64], log_core[64];
  bit log_mux[64], log_irq[64];

  initial forever begin
    @(negedge clk);
    step_done = 1'b0;
    thread_stop15 = '0;
    mux_grant = 1'b0;
    if (!rst_n) begin
      cd = 0;
      tstage = 0;
    end else begin
      if (cd > 0) begin
        cd--;
        if (cd == 0) step_done = 1'b1;
      end
      if (step_req) begin
        if (nlog < 64) begin
          log_id[nlog] = int'(step_id);
          log_core[nlog] = int'(step_core);
          log_mux[nlog] = mux_req;
          log_irq[nlog] = irq_block;
        end
        nlog++;
        cd = resp_delay;
      end
      mux_grant = grant_en && mux_req;
      if (mux_req) mux_seen = 1;
      if (tstage > 0) begin
        if (tstage <= NTHREAD) begin
          thread_stop15[THR_W-1:NTHREAD] = '1;
          if (!hi_only) begin
            thread_stop15[tstage-1] = 1'b1;
            chk(irq_block == 1'b1, "R6 irq held during rendezvous", int'(irq_block), 1);
          end
          tstage++;
        end else tstage = 0;
      end
      if (|thread_reset) begin
        trst_cnt++;
        chk(thread_reset == 8'h0F, "R5 thread reset mask", int'(thread_reset), 15);
        chk(irq_block == 1'b1, "R5 irq blocked at thread reset", int'(irq_block), 1);
        tstage = 1;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    wake_req = 1'b0;
    pd_req = 1'b0;
    repeat (3) @(negedge clk);
    nlog = 0;
    mux_seen = 0;
    trst_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic start_wake(input bit rt, input logic [3:0] mask);
    @(negedge clk);
    wake_req = 1'b1;
    wake_cores = mask;
    runtime = rt;
    @(negedge clk);
    wake_req = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
      if (err) break;
    end
  endtask

  task automatic check_log(input bit rt, input bit cache_off, input logic [3:0] eff,
                           input string tag);
    int exp_id[64], exp_core[64];
    int n = 0, bad = -1, bad_mux = 0, bad_irq = 0;
    if (cache_off)
      for (int s = 0; s < 10; s++) begin exp_id[n] = s; exp_core[n] = -1; n++; end
    for (int c = 0; c < NCORE; c++) begin
      if (eff[c]) begin
        for (int s = 10; s <= 16; s++) begin exp_id[n] = s; exp_core[n] = c; n++; end
        if (rt) begin exp_id[n] = 17; exp_core[n] = c; n++; end
      end
    end
    chk(nlog == n, {tag, " step count"}, nlog, n);
    for (int k = 0; k < n && k < nlog; k++) begin
      if (bad < 0 && (log_id[k] != exp_id[k] || (exp_core[k] >= 0 && log_core[k] != exp_core[k])))
        bad = k;
      if (rt && log_id[k] >= 10 && !log_mux[k]) bad_mux++;
      if ((log_id[k] == 17) != log_irq[k]) bad_irq++;
    end
    chk(bad < 0, {tag, " step order"}, (bad < 0) ? 0 : log_id[bad], (bad < 0) ? 0 : exp_id[bad]);
    chk(bad_mux == 0, "R4 core steps under mux", bad_mux, 0);
    chk(bad_irq == 0, "R5 irq block only from base load", bad_irq, 0);
  endtask

  task automatic do_pd(input logic [3:0] lvl, input logic [3:0] sel, input bit exp_ack,
                       input logic [3:0] exp_cores, input bit exp_cache, input string tag);
    @(negedge clk);
    pd_req = 1'b1;
    pd_level = lvl;
    pd_cores = sel;
    @(negedge clk);
    pd_req = 1'b0;
    chk(pd_ack == exp_ack && pd_nak == !exp_ack, {tag, " ack/nak"}, int'({pd_ack, pd_nak}),
        exp_ack ? 2 : 1);
    chk(core_pwr == exp_cores, {tag, " core power"}, int'(core_pwr), int'(exp_cores));
    chk(cache_pwr == exp_cache, {tag, " cache power"}, int'(cache_pwr), int'(exp_cache));
  endtask

  // {runtime, mask[3:0], responder delay[3:0]}
  localparam int NCASE = 5;
  localparam logic [8:0] CASES [NCASE] = '{
    {1'b0, 4'b0001, 4'd1},
    {1'b0, 4'b1010, 4'd3},
    {1'b1, 4'b0100, 4'd2},
    {1'b1, 4'b1111, 4'd1},
    {1'b0, 4'b0000, 4'd2}
  };

  initial begin
    #750000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit ok;
    // R11 reset state
    do_reset();
    @(negedge clk);
    chk({cache_pwr, core_pwr, busy, done, err, step_req, mux_req, irq_block} == '0,
        "R11 reset outputs", int'({cache_pwr, core_pwr, busy, done, err}), 0);
    chk(thread_reset == '0, "R11 thread reset idle", int'(thread_reset), 0);

    // table of wake cases: R1 R3 R4 R5
    for (int t = 0; t < NCASE; t++) begin
      do_reset();
      tmo_limit = 8'd8;
      resp_delay = int'(CASES[t][3:0]);
      grant_en = 1;
      hi_only = 0;
      start_wake(CASES[t][8], CASES[t][7:4]);
      wait_done(ok);
      chk(ok, "R8 done pulse", int'(ok), 1);
      chk(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
      chk(cache_pwr == 1'b1, "R1 cache up", int'(cache_pwr), 1);
      chk(core_pwr == CASES[t][7:4], "R3 cores up", int'(core_pwr), int'(CASES[t][7:4]));
      check_log(CASES[t][8], 1'b1, CASES[t][7:4], "R1 R3");
      if (!CASES[t][8]) chk(!mux_seen, "R4 no mux in boot", int'(mux_seen), 0);
      else chk(trst_cnt == $countones(CASES[t][7:4]), "R5 one thread reset per core",
               trst_cnt, $countones(CASES[t][7:4]));
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    end

    // R2: cache already up, powered core skipped
    do_reset();
    resp_delay = 1;
    start_wake(1'b0, 4'b0010);
    wait_done(ok);
    nlog = 0;
    start_wake(1'b1, 4'b0011);
    wait_done(ok);
    chk(ok, "R2 second wake done", int'(ok), 1);
    check_log(1'b1, 1'b0, 4'b0001, "R2 R3");
    chk(core_pwr == 4'b0011, "R3 both cores up", int'(core_pwr), 3);

    // R8: wake while busy ignored
    do_reset();
    resp_delay = 2;
    start_wake(1'b0, 4'b0001);
    repeat (5) @(negedge clk);
    wake_req = 1'b1;
    wake_cores = 4'b1000;
    runtime = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    wait_done(ok);
    chk(core_pwr == 4'b0001, "R8 busy wake ignored", int'(core_pwr), 1);
    check_log(1'b0, 1'b1, 4'b0001, "R8");
    chk(!mux_seen, "R8 ignored wake left no mux", int'(mux_seen), 0);

    // R7: completion on the last allowed cycle
    do_reset();
    tmo_limit = 8'd4;
    resp_delay = 4;
    start_wake(1'b0, 4'b0001);
    wait_done(ok);
    chk(ok && !err, "R7 done at limit accepted", int'(err), 0);

    // R7: one cycle late
    do_reset();
    resp_delay = 5;
    start_wake(1'b0, 4'b0001);
    wait_done(ok);
    chk(err == 1'b1, "R7 late step errors", int'(err), 1);
    chk(err_code == 5'd0, "R7 code names step", int'(err_code), 0);
    chk(busy == 1'b0, "R7 busy low in error", int'(busy), 0);
    repeat (20) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(err == 1'b1 && err_code == 5'd0, "R7 error sticky", int'(err_code), 0);
    chk(busy == 1'b0 && nlog == 1, "R7 wake ignored in error", nlog, 1);

    // R7: mux wait timeout
    do_reset();
    tmo_limit = 8'd6;
    resp_delay = 1;
    grant_en = 0;
    start_wake(1'b1, 4'b0010);
    wait_done(ok);
    chk(err && err_code == 5'd18, "R7 mux timeout code", int'(err_code), 18);
    chk(nlog == 10, "R4 no core step without grant", nlog, 10);
    chk(mux_req == 1'b0, "R7 mux released on error", int'(mux_req), 0);
    grant_en = 1;

    // R6/R7: only unused thread bits report
    do_reset();
    hi_only = 1;
    start_wake(1'b1, 4'b0001);
    wait_done(ok);
    chk(err && err_code == 5'd19, "R6 upper thread bits ignored", int'(err_code), 19);
    chk(core_pwr == 4'b0000, "R6 core not completed", int'(core_pwr), 0);
    hi_only = 0;

    // R7: zero limit waits forever
    do_reset();
    tmo_limit = 8'd0;
    resp_delay = 0;
    start_wake(1'b0, 4'b0001);
    repeat (300) @(negedge clk);
    chk(!err && busy, "R7 zero limit never expires", int'(err), 0);
    chk(nlog == 1, "R7 still on first step", nlog, 1);

    // R9 / R10 power-down
    do_reset();
    tmo_limit = 8'd8;
    resp_delay = 1;
    start_wake(1'b0, 4'b0011);
    wait_done(ok);
    do_pd(4'd12, 4'b0001, 1'b0, 4'b0011, 1'b1, "R10 cache off refused");
    do_pd(4'd3, 4'b0011, 1'b1, 4'b0011, 1'b1, "R9 shallow level no change");
    do_pd(4'd6, 4'b0001, 1'b1, 4'b0010, 1'b1, "R9 core level");
    do_pd(4'd12, 4'b0010, 1'b1, 4'b0000, 1'b0, "R9 cache level");
    resp_delay = 2;
    start_wake(1'b0, 4'b0001);
    repeat (3) @(negedge clk);
    do_pd(4'd6, 4'b0001, 1'b0, 4'b0000, 1'b0, "R10 refused while busy");
    wait_done(ok);
    chk(core_pwr == 4'b0001 && cache_pwr, "R10 wake after refusal", int'(core_pwr), 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule